// File: doc/BRIEF.md
# JTAG Debug Module Selector

This block is the front end of a JTAG debug unit that shares one user data register among four debug submodules: a bus-access module, two CPU control modules and a serial-port module. Every data-register scan passes through it. It watches the bits as they shift in and, when the scan ends, reads the last bit shifted as a flag.

A scan whose flag is 1 is a selection command. The two bits shifted just before the flag name the submodule to make current, and that choice is held across later scans. A scan whose flag is 0 belongs to the current submodule. It receives the capture and shift strobes as they happen, together with the raw TDI stream, and then the update strobe. The serial output of the current submodule is routed to TDO.

After reset no submodule is current. TDO is then 0 and no strobe reaches any submodule. The TAP controller and the submodules sit outside this block. Its strobes are levels sampled on the rising edge of TCK.

Top module: `dbg_route_top`

## Requirements
- R1: While `rst_n` is low at a TCK edge, the selection is cleared. After that, `sub_sel`, `sub_shift`, `sub_capture`, `sub_update` and `tdo` are all 0 until a selection command completes.
- R2: Bits enter least significant first. At update, the last bit shifted is the flag, the bit before it is index bit 1, and the bit before that is index bit 0. Earlier bits of a longer scan have no effect. Bit positions not reached by a short scan read as 0.
- R3: An update with the flag at 1 latches the index, and `sub_sel` shows the new choice from the next cycle on.
- R4: Index 0 selects the bus-access module (`sub_sel` bit 0), 1 selects CPU0 (bit 1), 2 selects CPU1 (bit 2) and 3 selects the serial-port module (bit 3). `sub_sel` is one-hot or all zero.
- R5: An update with the flag at 0 is passed on `sub_update` to the current submodule only, and leaves the selection unchanged. With no submodule current, it reaches none.
- R6: `shift_en` and `capture_en` are passed, in the same cycle, only to the bit of `sub_shift` and `sub_capture` that belongs to the current submodule.
- R7: The update that ends a selection scan reaches no submodule, neither the old one nor the new one.
- R8: `tdo` equals the `sub_tdo` bit of the current submodule in the same cycle, and is 0 when none is current.
- R9: The selection changes only at an update strobe. Capture and shift cycles leave it unchanged, even when the bits shifted form a selection pattern.
- R10: A capture clears the command bits, so an update that follows a capture with no shift in between is a forwarded command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset (test-logic reset) |
| capture_en | input | 1 | Capture-DR strobe for the user register |
| shift_en | input | 1 | Shift-DR strobe for the user register |
| update_en | input | 1 | Update-DR strobe for the user register |
| tdi | input | 1 | Serial data in |
| sub_tdo | input | 4 | Serial outputs of the submodules, one bit each |
| sub_sel | output | 4 | One-hot enable of the current submodule |
| sub_capture | output | 4 | Capture strobe for each submodule |
| sub_shift | output | 4 | Shift strobe for each submodule |
| sub_update | output | 4 | Update strobe for each submodule |
| tdo | output | 1 | Serial data out |

## Verification
Two things can happen on the same update strobe: the selection register latching a new index, and the forwarding path passing the update on. The bench provokes this collision by running selection scans directly after forwarded scans to every submodule. In the update cycle it checks that no `sub_update` bit rises (R7), and one cycle later that `sub_sel` has moved to the new index. A behavioural model, built on a queue of shifted bits, predicts every output at each falling edge. This makes a forwarded update that leaks to the old or new module, or a selection that moves a cycle early, show up as a mismatch.

// File: rtl/dbg_route_pkg.sv
// Package: shared constants and types of the debug module selector.
// Assumes: the selection index is two bits wide, giving four submodules.
package dbg_route_pkg;

    // Width of the selection index carried by a selection command.
    localparam int unsigned ROUTE_ID_W = 2;

    // Submodule roles. The numeric value is the index a selection command carries.
    typedef enum logic [ROUTE_ID_W-1:0] {
        DMOD_BUS   = 2'd0,
        DMOD_CPU_A = 2'd1,
        DMOD_CPU_B = 2'd2,
        DMOD_SPORT = 2'd3
    } dmod_e;

    // Meaning of a completed scan, taken from its flag bit.
    typedef enum logic {
        SCAN_FORWARD = 1'b0,
        SCAN_SELECT  = 1'b1
    } scan_kind_e;

endpackage

// File: rtl/dbg_cmd_shreg.sv
// Module: command shift register.
// Keeps the last CMD_W bits shifted in, with the newest bit at the top.
// A capture clears it, so bits that no shift reached read as zero.
// Assumes: capture and shift are never asserted together. If they are, capture wins.
module dbg_cmd_shreg #(
    parameter int unsigned CMD_W = 3
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             capture_en,
    input  logic             shift_en,
    input  logic             tdi,
    output logic [CMD_W-1:0] cmd_q
);

    // Clear on reset or capture; otherwise shift the new bit in at the top.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (capture_en) begin
            cmd_q <= '0;
        end else if (shift_en) begin
            cmd_q <= {tdi, cmd_q[CMD_W-1:1]};
        end
    end

endmodule

// File: rtl/dbg_sel_reg.sv
// Module: selection register.
// Holds a valid bit and the index of the current submodule, and decodes them to one-hot.
// Assumes: load_sel is asserted only in an update cycle of a selection scan.
module dbg_sel_reg #(
    parameter int unsigned ID_W  = 2,
    localparam int unsigned N_MOD = 1 << ID_W
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             load_sel,
    input  logic [ID_W-1:0]  new_id,
    output logic             sel_valid,
    output logic [ID_W-1:0]  sel_id,
    output logic [N_MOD-1:0] sel_oh
);

    // Load the index on a selection update; reset leaves nothing selected.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            sel_valid <= 1'b0;
            sel_id    <= '0;
        end else if (load_sel) begin
            sel_valid <= 1'b1;
            sel_id    <= new_id;
        end
    end

    // One-hot decode, one bit per submodule.
    for (genvar k = 0; k < N_MOD; k++) begin : g_dec
        assign sel_oh[k] = sel_valid && (sel_id == ID_W'(k));
    end

endmodule

// File: rtl/dbg_fwd_mux.sv
// Module: strobe forwarding and TDO return path.
// Gates the TAP strobes with the one-hot selection, suppresses the update of a
// selection scan, and ORs together the gated submodule outputs to form TDO.
// Assumes: sel_oh is one-hot or all zero.
module dbg_fwd_mux #(
    parameter int unsigned N_MOD = 4
) (
    input  logic             capture_en,
    input  logic             shift_en,
    input  logic             update_en,
    input  logic             is_select,
    input  logic [N_MOD-1:0] sel_oh,
    input  logic [N_MOD-1:0] sub_tdo,
    output logic [N_MOD-1:0] sub_capture,
    output logic [N_MOD-1:0] sub_shift,
    output logic [N_MOD-1:0] sub_update,
    output logic             tdo
);

    logic [N_MOD-1:0] tdo_gated;

    // Per-submodule gating of strobes and serial output.
    for (genvar k = 0; k < N_MOD; k++) begin : g_lane
        assign sub_capture[k] = capture_en && sel_oh[k];
        assign sub_shift[k]   = shift_en && sel_oh[k];
        assign sub_update[k]  = update_en && !is_select && sel_oh[k];
        assign tdo_gated[k]   = sub_tdo[k] && sel_oh[k];
    end

    // Return path: at most one gated bit can be set.
    always_comb begin
        tdo = |tdo_gated;
    end

endmodule

// File: rtl/dbg_route_top.sv
// Module: debug module selector (top).
// Sits behind one user data register. A scan whose last bit is 1 selects a
// submodule. Any other scan is routed, with its strobes, to the current submodule.
// Assumes: strobes come from a TAP controller as levels sampled on rising TCK.
module dbg_route_top #(
    parameter int unsigned ID_W = dbg_route_pkg::ROUTE_ID_W,
    localparam int unsigned N_MOD = 1 << ID_W,
    localparam int unsigned CMD_W = ID_W + 1
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             capture_en,
    input  logic             shift_en,
    input  logic             update_en,
    input  logic             tdi,
    input  logic [N_MOD-1:0] sub_tdo,
    output logic [N_MOD-1:0] sub_sel,
    output logic [N_MOD-1:0] sub_capture,
    output logic [N_MOD-1:0] sub_shift,
    output logic [N_MOD-1:0] sub_update,
    output logic             tdo
);

    import dbg_route_pkg::*;

    logic [CMD_W-1:0] cmd_q;
    scan_kind_e       scan_kind;
    logic             sel_valid;
    logic [ID_W-1:0]  sel_id;
    logic [N_MOD-1:0] sel_oh;

    // Command bits of the scan in progress.
    dbg_cmd_shreg #(.CMD_W(CMD_W)) u_shreg (
        .tck        (tck),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .tdi        (tdi),
        .cmd_q      (cmd_q)
    );

    // Classify the scan from its top bit.
    always_comb begin
        scan_kind = scan_kind_e'(cmd_q[CMD_W-1]);
    end

    // Selection register, loaded only by the update of a selection scan.
    dbg_sel_reg #(.ID_W(ID_W)) u_sel (
        .tck       (tck),
        .rst_n     (rst_n),
        .load_sel  (update_en && (scan_kind == SCAN_SELECT)),
        .new_id    (cmd_q[ID_W-1:0]),
        .sel_valid (sel_valid),
        .sel_id    (sel_id),
        .sel_oh    (sel_oh)
    );

    // Strobe routing and TDO return.
    dbg_fwd_mux #(.N_MOD(N_MOD)) u_mux (
        .capture_en  (capture_en),
        .shift_en    (shift_en),
        .update_en   (update_en),
        .is_select   (scan_kind == SCAN_SELECT),
        .sel_oh      (sel_oh),
        .sub_tdo     (sub_tdo),
        .sub_capture (sub_capture),
        .sub_shift   (sub_shift),
        .sub_update  (sub_update),
        .tdo         (tdo)
    );

    // Enables to the submodules.
    always_comb begin
        sub_sel = sel_oh;
    end

endmodule

// File: rtl/dbg_route_chk.sv
// Module: assertion checker for dbg_route_top, attached with bind below.
module dbg_route_chk #(
    parameter int unsigned ID_W = 2,
    localparam int unsigned N_MOD = 1 << ID_W,
    localparam int unsigned CMD_W = ID_W + 1
) (
    input logic             tck,
    input logic             rst_n,
    input logic             capture_en,
    input logic             shift_en,
    input logic             update_en,
    input logic [CMD_W-1:0] cmd_q,
    input logic [N_MOD-1:0] sub_sel,
    input logic [N_MOD-1:0] sub_update,
    input logic             tdo
);

    localparam logic [N_MOD-1:0] ONE = 1;

    // R1
    reset_clear_chk: assert property (@(posedge tck) !rst_n |=> (sub_sel == '0));

    // R3
    select_load_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (update_en && cmd_q[CMD_W-1]) |=> (sub_sel == (ONE << $past(cmd_q[ID_W-1:0]))));

    // R4
    sel_onehot_chk: assert property (@(posedge tck) disable iff (!rst_n) $onehot0(sub_sel));

    // R5
    fwd_keeps_sel_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (update_en && !cmd_q[CMD_W-1]) |=> $stable(sub_sel));

    // R7
    select_no_fwd_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (update_en && cmd_q[CMD_W-1]) |-> (sub_update == '0));

    // R8
    idle_tdo_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (sub_sel == '0) |-> !tdo);

    // R9
    sel_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (!update_en && (capture_en || shift_en)) |=> $stable(sub_sel));

endmodule

bind dbg_route_top dbg_route_chk #(.ID_W(ID_W)) u_chk (
    .tck        (tck),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .update_en  (update_en),
    .cmd_q      (cmd_q),
    .sub_sel    (sub_sel),
    .sub_update (sub_update),
    .tdo        (tdo)
);

// File: tb/tb_dbg_route_top.sv
module tb_dbg_route_top;

    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       capture_en = 1'b0;
    logic       shift_en = 1'b0;
    logic       update_en = 1'b0;
    logic       tdi = 1'b0;
    logic [3:0] sub_tdo = 4'hF;
    logic [3:0] sub_sel, sub_capture, sub_shift, sub_update;
    logic       tdo;

    int  compared = 0;
    int  mismatched = 0;
    int  cycles = 0;
    bit  started = 0;
    bit  rand_tdo = 1;

    // Behavioural reference state.
    int  m_sel = -1;
    bit  hist[$];

    always #4 tck = ~tck;

    dbg_route_top dut (
        .tck(tck), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .tdi(tdi), .sub_tdo(sub_tdo), .sub_sel(sub_sel),
        .sub_capture(sub_capture), .sub_shift(sub_shift), .sub_update(sub_update),
        .tdo(tdo)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic bit m_flag();
        return (hist.size() >= 1) ? hist[hist.size()-1] : 1'b0;
    endfunction

    function automatic int m_idx();
        int v = 0;
        if (hist.size() >= 2) v += 2 * int'(hist[hist.size()-2]);
        if (hist.size() >= 3) v += int'(hist[hist.size()-3]);
        return v;
    endfunction

    // Reference model update on each rising edge.
    always @(posedge tck) begin
        cycles++;
        started = 1;
        if (!rst_n) begin
            m_sel = -1;
            hist.delete();
        end else begin
            if (update_en && m_flag()) m_sel = m_idx();
            if (capture_en) hist.delete();
            else if (shift_en) begin
                hist.push_back(tdi);
                if (hist.size() > 3) void'(hist.pop_front());
            end
        end
    end

    // Whole-output comparison at every falling edge.
    always @(negedge tck) begin
        if (started) begin
            logic [3:0] e_sel;
            e_sel = (m_sel < 0) ? 4'h0 : 4'(1 << m_sel);
            chk("R3/R4 sub_sel", 32'(sub_sel), 32'(e_sel));
            chk("R6 sub_shift", 32'(sub_shift), shift_en ? 32'(e_sel) : 32'h0);
            chk("R6 sub_capture", 32'(sub_capture), capture_en ? 32'(e_sel) : 32'h0);
            chk("R5/R7 sub_update", 32'(sub_update),
                (update_en && !m_flag()) ? 32'(e_sel) : 32'h0);
            chk("R8 tdo", 32'(tdo), (m_sel < 0) ? 32'h0 : 32'(sub_tdo[m_sel]));
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge tck) begin
        if (cycles > 150000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic step(input bit c, input bit s, input bit u, input bit b);
        @(posedge tck);
        #1;
        capture_en = c;
        shift_en   = s;
        update_en  = u;
        tdi        = b;
        if (rand_tdo) sub_tdo = 4'($urandom % 16);
    endtask

    // Capture, n shifts of v (LSB first), then an update left driven.
    task automatic scan(input logic [31:0] v, input int n);
        step(1, 0, 0, 0);
        for (int i = 0; i < n; i++) step(0, 1, 0, v[i]);
        step(0, 0, 1, 0);
    endtask

    task automatic do_select(input int k);
        scan(32'(4 | k), 3);
        @(negedge tck);
        chk("R7 select update not forwarded", 32'(sub_update), 32'h0);
        step(0, 0, 0, 0);
        @(negedge tck);
        chk("R4 selected index", 32'(sub_sel), 32'(1 << k));
    endtask

    initial begin
        // R1: reset state
        repeat (3) step(0, 0, 0, 0);
        @(negedge tck);
        chk("R1 sub_sel after reset", 32'(sub_sel), 32'h0);
        chk("R1 tdo after reset", 32'(tdo), 32'h0);
        @(posedge tck); #1; rst_n = 1'b1;

        // R5/R6: forwarded scan with nothing selected reaches nobody
        scan(32'h0B, 5);
        @(negedge tck);
        chk("R5 update with no selection", 32'(sub_update), 32'h0);
        step(0, 0, 0, 0);

        // R3/R4/R5/R7/R8: select each module, forward to it, then move on
        for (int k = 0; k < 4; k++) begin
            do_select(k);
            scan(32'h3A5, 12);
            @(negedge tck);
            chk("R5 forwarded update", 32'(sub_update), 32'(1 << k));
            step(0, 0, 0, 0);
            @(negedge tck);
            chk("R9 selection kept after forward", 32'(sub_sel), 32'(1 << k));
            rand_tdo = 0;
            @(posedge tck); #1; sub_tdo = 4'(1 << k);
            @(negedge tck);
            chk("R8 tdo follows selected high", 32'(tdo), 32'h1);
            @(posedge tck); #1; sub_tdo = ~4'(1 << k);
            @(negedge tck);
            chk("R8 tdo follows selected low", 32'(tdo), 32'h0);
            rand_tdo = 1;
        end

        // R2: long scan, only the last three bits count
        do_select(1);
        scan(32'b1100110101, 10);
        step(0, 0, 0, 0);
        @(negedge tck);
        chk("R2 long select scan", 32'(sub_sel), 32'h4);
        scan(32'b1110010, 7);
        step(0, 0, 0, 0);
        @(negedge tck);
        chk("R2 seven-bit select scan", 32'(sub_sel), 32'h8);
        // R2: two-bit scan, index bit 0 unreached reads 0 -> index 2
        scan(32'b11, 2);
        step(0, 0, 0, 0);
        @(negedge tck);
        chk("R2 short select scan", 32'(sub_sel), 32'h4);

        // R10: capture clears command bits; empty scan forwards
        do_select(0);
        scan(32'h0, 0);
        @(negedge tck);
        chk("R10 empty scan forwarded", 32'(sub_update), 32'h1);
        step(0, 0, 0, 0);

        // R9: a selection pattern shifted without update changes nothing
        step(1, 0, 0, 0);
        step(0, 1, 0, 1);
        step(0, 1, 0, 1);
        step(0, 1, 0, 1);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        @(negedge tck);
        chk("R9 shift without update", 32'(sub_sel), 32'h1);
        step(1, 0, 0, 0);
        step(0, 0, 1, 0);
        @(negedge tck);
        chk("R10 capture cleared pending flag", 32'(sub_update), 32'h1);
        step(0, 0, 0, 0);

        // R1: reset mid-run clears the selection
        do_select(2);
        @(posedge tck); #1; rst_n = 1'b0;
        @(posedge tck); #1; rst_n = 1'b1;
        @(negedge tck);
        chk("R1 sub_sel after late reset", 32'(sub_sel), 32'h0);
        chk("R1 tdo after late reset", 32'(tdo), 32'h0);
        repeat (4) step(0, 0, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule